// File: doc/BRIEF.md
# Chip-Erase Status and Interrupt Register

This block is an 8-bit register that software reads and writes over a simple CPU register bus. It tracks the outcome of a flash chip-erase operation. It holds three state bits:

- an erase-done flag;
- an erase-failure flag;
- an interrupt enable for the failure flag.

The erase sequencer drives three single-cycle event pulses into the block: done, hang and timeout. The block drives an interrupt request and a program/erase lock indication back to the sequencer.

Both flags are cleared by writing 0, and writing 1 to a flag does nothing. A read-modify-write read cycle returns both flags as 1. Because of this, a read-modify-write instruction that touches a neighbouring bit writes 1 back to the flags and leaves them unchanged. When software clears the done flag while it is set, the block locks further program/erase operations. A reset command from the command decoder unlocks them again.

Top module: `erase_stat_reg`

## Requirements
- R1: Bits 7 and 3..0 of `rd_data` always read 0, and writes to them change no state.
- R2: A `seq_done` pulse with no `seq_hang` in the same cycle sets the done flag, which reads at bit 6, on the next clock edge.
- R3: A write with bit 6 or bit 4 at 0 clears the done flag or the failure flag respectively. A write with that bit at 1 leaves the flag unchanged.
- R4: A `seq_hang` pulse forces the done flag to 0 and sets the failure flag, which reads at bit 4. The hang takes priority over a `seq_done` pulse in the same cycle.
- R5: A `seq_tmo` pulse sets the failure flag on the next clock edge.
- R6: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R7: While `rmw_rd` is high, bits 6 and 4 of `rd_data` read 1 whatever their state. The read itself changes no state.
- R8: Bit 5 is a plain read/write interrupt enable. `irq` equals the AND of the enable and the failure flag as they stood before the previous clock edge, so it lags them by one cycle.
- R9: A software write that clears the done flag while it is set raises `pgm_lock` on the next edge. This happens only when no `seq_done`, `seq_hang` or `reset_cmd` arrives in the same cycle. `pgm_lock` then stays high, even across later done events.
- R10: `reset_cmd` drops `pgm_lock` on the next edge. It takes priority over a lock request in the same cycle.
- R11: After reset all register bits, `irq` and `pgm_lock` are 0.
- R12: `rd_data` is 0 when neither `rd_en` nor `rmw_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Normal read strobe |
| rmw_rd | input | 1 | Read strobe of a read-modify-write access |
| rd_data | output | 8 | Read data |
| seq_done | input | 1 | Sequencer pulse: chip erase finished |
| seq_hang | input | 1 | Sequencer pulse: chip erase failed (hang) |
| seq_tmo | input | 1 | Sequencer pulse: erase timeout/failure |
| reset_cmd | input | 1 | Reset command seen by the command decoder |
| irq | output | 1 | Failure interrupt request |
| pgm_lock | output | 1 | Program/erase lock to the sequencer |

## Verification
The bench targets the collisions between event pulses and software writes in one cycle. A design that let a software clear win would lose a done or timeout event. A design that let `seq_done` beat `seq_hang` would report success on a failed erase. A design that locked on a clear racing a fresh done event, or on a clear racing `reset_cmd`, would block programming with no cause.

The bench also checks that the lock survives a later done event. It checks that a read-modify-write read returns 1 on clear flags without changing them, and that `irq` lags the enable and flag by exactly one cycle, both when it rises and when it falls.

// File: rtl/erase_stat_reg.sv
module erase_stat_reg #(
  parameter int W        = 8,
  parameter int DONE_BIT = 6,
  parameter int EN_BIT   = 5,
  parameter int FAIL_BIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rmw_rd,
  output logic [W-1:0] rd_data,
  input  logic         seq_done,
  input  logic         seq_hang,
  input  logic         seq_tmo,
  input  logic         reset_cmd,
  output logic         irq,
  output logic         pgm_lock
);

  logic done_q, en_q, fail_q, lock_q, irq_q;
  logic [W-1:0] view;

  wire sw_clr_done = wr_en & ~wr_data[DONE_BIT];
  wire sw_clr_fail = wr_en & ~wr_data[FAIL_BIT];
  wire lock_req    = sw_clr_done & done_q & ~seq_done & ~seq_hang;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      en_q   <= 1'b0;
      fail_q <= 1'b0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (seq_hang)         done_q <= 1'b0;
      else if (seq_done)    done_q <= 1'b1;
      else if (sw_clr_done) done_q <= 1'b0;

      if (seq_hang || seq_tmo) fail_q <= 1'b1;
      else if (sw_clr_fail)    fail_q <= 1'b0;

      if (wr_en) en_q <= wr_data[EN_BIT];

      if (reset_cmd)     lock_q <= 1'b0;
      else if (lock_req) lock_q <= 1'b1;

      irq_q <= en_q & fail_q;
    end
  end

  always_comb begin
    view           = '0;
    view[DONE_BIT] = done_q | rmw_rd;
    view[EN_BIT]   = en_q;
    view[FAIL_BIT] = fail_q | rmw_rd;
  end

  assign rd_data  = (rd_en | rmw_rd) ? view : '0;
  assign irq      = irq_q;
  assign pgm_lock = lock_q;

endmodule

// File: rtl/erase_stat_chk.sv
module erase_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rmw_rd,
  input logic [7:0] rd_data,
  input logic       seq_done,
  input logic       seq_hang,
  input logic       seq_tmo,
  input logic       reset_cmd,
  input logic       irq,
  input logic       pgm_lock,
  input logic       done_q,
  input logic       en_q,
  input logic       fail_q
);

  assert_unused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0 && rd_data[3:0] == 4'h0);

  assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !seq_hang |=> done_q);

  assert_write_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[6] && !done_q && !seq_done |=> !done_q);

  assert_hang_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hang |=> !done_q && fail_q);

  assert_tmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_tmo |=> fail_q);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !seq_hang && wr_en && !wr_data[6] |=> done_q);

  assert_rmw_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_rd |-> rd_data[6] && rd_data[4]);

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && fail_q |=> irq);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq);

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[6] && done_q && !seq_done && !seq_hang && !reset_cmd |=> pgm_lock);

  assert_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> !pgm_lock);

endmodule

bind erase_stat_reg erase_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rmw_rd(rmw_rd), .rd_data(rd_data), .seq_done(seq_done),
  .seq_hang(seq_hang), .seq_tmo(seq_tmo), .reset_cmd(reset_cmd),
  .irq(irq), .pgm_lock(pgm_lock), .done_q(done_q), .en_q(en_q),
  .fail_q(fail_q)
);

// File: tb/test_erase_stat_reg.sv
`timescale 1ns/1ps
module test_erase_stat_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b1, rmw_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       seq_done = 1'b0, seq_hang = 1'b0, seq_tmo = 1'b0, reset_cmd = 1'b0;
  logic [7:0] rd_data;
  logic       irq, pgm_lock;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  erase_stat_reg i_erase_stat_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rmw_rd(rmw_rd), .rd_data(rd_data),
    .seq_done(seq_done), .seq_hang(seq_hang), .seq_tmo(seq_tmo),
    .reset_cmd(reset_cmd), .irq(irq), .pgm_lock(pgm_lock)
  );

  // stim {done,hang,tmo,rcmd,wr,rmw}, wdata, expected rd_data, irq, lock
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {6'b000000, 8'h00, 8'h00, 1'b0, 1'b0},  // 0  R11 idle after reset
    {6'b100000, 8'h00, 8'h40, 1'b0, 1'b0},  // 1  R2 done sets
    {6'b000010, 8'hFF, 8'h60, 1'b0, 1'b0},  // 2  R3 ones do nothing, R1 unused
    {6'b000001, 8'h00, 8'h70, 1'b0, 1'b0},  // 3  R7 rmw reads ones
    {6'b001000, 8'h00, 8'h70, 1'b0, 1'b0},  // 4  R5 timeout sets fail
    {6'b000000, 8'h00, 8'h70, 1'b1, 1'b0},  // 5  R8 irq one cycle later
    {6'b000010, 8'h60, 8'h60, 1'b1, 1'b0},  // 6  R3 clear fail
    {6'b000000, 8'h00, 8'h60, 1'b0, 1'b0},  // 7  R8 irq falls
    {6'b000010, 8'h20, 8'h20, 1'b0, 1'b1},  // 8  R9 clear done locks
    {6'b100000, 8'h00, 8'h60, 1'b0, 1'b1},  // 9  R9 lock survives done
    {6'b000100, 8'h00, 8'h60, 1'b0, 1'b0},  // 10 R10 reset command
    {6'b100010, 8'h20, 8'h60, 1'b0, 1'b0},  // 11 R6 set beats clear, no lock
    {6'b010000, 8'h00, 8'h30, 1'b0, 1'b0},  // 12 R4 hang
    {6'b000000, 8'h00, 8'h30, 1'b1, 1'b0},  // 13 R8
    {6'b000010, 8'h10, 8'h10, 1'b1, 1'b0},  // 14 R8 enable dropped
    {6'b000000, 8'h00, 8'h10, 1'b0, 1'b0},  // 15 R8
    {6'b001010, 8'h00, 8'h10, 1'b0, 1'b0},  // 16 R6 timeout beats clear
    {6'b000010, 8'h00, 8'h00, 1'b0, 1'b0},  // 17 R3
    {6'b110000, 8'h00, 8'h10, 1'b0, 1'b0},  // 18 R4 hang beats done
    {6'b000010, 8'h00, 8'h00, 1'b0, 1'b0},  // 19 R3
    {6'b100000, 8'h00, 8'h40, 1'b0, 1'b0},  // 20 R2
    {6'b000110, 8'h00, 8'h00, 1'b0, 1'b0},  // 21 R10 reset command beats lock
    {6'b000001, 8'h00, 8'h50, 1'b0, 1'b0}   // 22 R7 rmw on clear flags
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R11";  1: return "R2";   2: return "R3";   3: return "R7";
      4: return "R5";   5: return "R8";   6: return "R3";   7: return "R8";
      8: return "R9";   9: return "R9";   10: return "R10"; 11: return "R6";
      12: return "R4";  13: return "R8";  14: return "R8";  15: return "R8";
      16: return "R6";  17: return "R3";  18: return "R4";  19: return "R3";
      20: return "R2";  21: return "R10"; default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] er, logic ei, logic el);
    n_chk++;
    if (rd_data !== er || irq !== ei || pgm_lock !== el) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h irq=%b lock=%b expected rd_data=%h irq=%b lock=%b",
               req, rd_data, irq, pgm_lock, er, ei, el);
    end
  endtask

  task automatic drive(logic [5:0] s, logic [7:0] d);
    @(negedge clk);
    {seq_done, seq_hang, seq_tmo, reset_cmd, wr_en, rmw_rd} = s;
    wr_data = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: expired expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R11", 8'h00, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23:18], VEC[i][17:10]);
      check(tag_of(i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R12: no read strobe gives zero data, even with flags set
    drive(6'b100010, 8'hFF);
    rd_en = 1'b0;
    #1 check("R12", 8'h00, 1'b0, 1'b0);
    rd_en = 1'b1;
    #1 check("R12", 8'h60, 1'b0, 1'b0);

    // build full state, then reset mid-run: R11
    drive(6'b001000, 8'h00);
    drive(6'b000010, 8'h30);
    drive(6'b000000, 8'h00);
    check("R11", 8'h30, 1'b1, 1'b1);
    @(negedge clk);
    {seq_done, seq_hang, seq_tmo, reset_cmd, wr_en, rmw_rd} = '0;
    rst_n = 1'b0;
    #2 check("R11", 8'h00, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    drive(6'b000000, 8'h00);
    check("R11", 8'h00, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule